// File: doc/BRIEF.md
# High/Low Time Programmable Clock Divider

This block divides an input clock into a one-cycle enable pulse and a square-wave output. The ratio does not come from a single divisor field. It is set by two 32-bit control words. The timing word holds a low count and a high count. The flags word holds four modifier bits: a one-cycle edge extension, a pre-divide-by-two stage, a half-cycle add and a phase-placement select. The divider samples a new configuration only at a period boundary, so a rewrite in mid-period cannot produce a short period.

An encoder travels with the divider. It turns a requested integer divide value into the two words. The output-stage style uses the pre-divide-by-two stage and quarter counts. The feedback/input style uses half counts and the edge bit. The encoder keeps every unrelated bit of a previous flags word and clears the stale modifier bits. Software or a sequencer can drive the encoder outputs straight into the divider's word inputs.

Top module: `hl_time_divider`

## Requirements
- R1: Flags word bits: bit 8 is edge, bit 11 is pre-divide-by-two, bit 13 is half-cycle add and bit 15 is phase select. Timing word bits: 7:0 hold the low count and 15:8 hold the high count. The base count is low + high + edge, and a base count of 0 is treated as 1.
- R2: With bit 11 set, the divide ratio R is 2 × base + bit 13. With bit 11 clear, R equals the base count. Successive `tick_o` pulses are exactly R clock cycles apart.
- R3: Across each period, `wave_o` is high for R − floor(R/2) cycles and low for the rest. The exception is an odd R with bit 11 set and bit 15 clear: then the extra cycle goes to the low phase (high for floor(R/2)). The output is low first and ends high when the period closes.
- R4: `tick_o` is high for exactly one cycle per period. At R = 1 it is high on every cycle.
- R5: The control words are sampled only in the last cycle of a period. A change in mid-period leaves the running period at its old length.
- R6: While `rst_ni` is low, `tick_o` and `wave_o` are low for any R > 1. After release, `tick_o` is first high after R − 1 rising edges.
- R7: Encoder output style (`enc_fb_mode_i` = 0), for value N: bit 11 is set, bit 8 = (N mod 4 > 1), bits 13 and 15 = N mod 2, and low = high = N/4. Every other flags bit is copied from `enc_prev_flags_i`.
- R8: Encoder feedback style (`enc_fb_mode_i` = 1): bits 11 and 13 are cleared, bit 8 = N mod 2, and low = high = N/2. Every other flags bit, bit 15 included, is copied from `enc_prev_flags_i`.
- R9: When the encoder output drives the divider, the tick spacing equals N. This holds for N from 2 to 511 in output style and from 2 to 255 in feedback style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flags_i | input | 32 | Modifier flags word |
| timing_i | input | 32 | Low/high count word |
| tick_o | output | 1 | One-cycle enable per divided period |
| wave_o | output | 1 | Divided square wave |
| enc_value_i | input | 9 | Requested divide value for the encoder |
| enc_fb_mode_i | input | 1 | Encoder style: 0 output, 1 feedback/input |
| enc_prev_flags_i | input | 32 | Previous flags word to merge into |
| enc_flags_o | output | 32 | Encoded flags word |
| enc_timing_o | output | 32 | Encoded timing word |

## Verification
Different internal faults show up at the ports in different ways:
- A wrong latched ratio, or a counter that skips its wrap, shows up in the very next `tick_o` spacing.
- A wrong phase threshold changes the count of high `wave_o` cycles inside that same period.
- A configuration taken before the boundary shortens the period in which the words were rewritten.
- An encoder slip on one divide value changes that value's spacing within one period.

For these reasons the bench measures the spacing and the high count of every period it drives. It sweeps every divide value it supports through the encoder.

// File: rtl/hl_div_pkg.sv
package hl_div_pkg;
  // Flag bit positions decoded by the divider and produced by the encoder
  localparam int unsigned EDGE_BIT   = 8;
  localparam int unsigned PREDIV_BIT = 11;
  localparam int unsigned HALF_BIT   = 13;
  localparam int unsigned PHASE_BIT  = 15;

  typedef enum logic {
    ENC_OUT = 1'b0,
    ENC_FB  = 1'b1
  } enc_mode_e;
endpackage

// File: rtl/hl_div_decode.sv
module hl_div_decode #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned RATIO_W = FIELD_W + 2
) (
  input  logic [WORD_W-1:0]  flags_i,
  input  logic [WORD_W-1:0]  timing_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               extra_low_o
);
  import hl_div_pkg::*;

  logic [FIELD_W-1:0] low_cnt, high_cnt;
  logic [FIELD_W:0]   base_raw, base_cnt;
  logic               edge_b, prediv_b, half_b, phase_b;

  assign low_cnt  = timing_i[FIELD_W-1:0];
  assign high_cnt = timing_i[2*FIELD_W-1:FIELD_W];
  assign edge_b   = flags_i[EDGE_BIT];
  assign prediv_b = flags_i[PREDIV_BIT];
  assign half_b   = flags_i[HALF_BIT];
  assign phase_b  = flags_i[PHASE_BIT];

  always_comb begin
    base_raw = {1'b0, low_cnt} + {1'b0, high_cnt} + {{FIELD_W{1'b0}}, edge_b};
    base_cnt = (base_raw == '0) ? {{FIELD_W{1'b0}}, 1'b1} : base_raw;
    if (prediv_b) ratio_o = {base_cnt, 1'b0} + {{(RATIO_W-1){1'b0}}, half_b};
    else          ratio_o = {1'b0, base_cnt};
  end

  // odd extra cycle lands in the low phase only in pre-divide mode with phase select clear
  assign extra_low_o = prediv_b & ~phase_b;

  always_comb begin
    assert_ratio_nonzero_R1: assert (ratio_o != '0);
    assert_prediv_even_R2: assert (!(prediv_b && !half_b) || !ratio_o[0]);
  end
endmodule

// File: rtl/hl_div_encode.sv
module hl_div_encode #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned DIV_W   = 9
) (
  input  logic [DIV_W-1:0]       value_i,
  input  hl_div_pkg::enc_mode_e  mode_i,
  input  logic [WORD_W-1:0]      prev_flags_i,
  output logic [WORD_W-1:0]      flags_o,
  output logic [WORD_W-1:0]      timing_o
);
  import hl_div_pkg::*;

  logic [FIELD_W-1:0] cnt_field;
  logic [DIV_W-1:0]   quarter, half;

  assign quarter = value_i >> 2;
  assign half    = value_i >> 1;

  always_comb begin
    flags_o = prev_flags_i;
    flags_o[EDGE_BIT] = 1'b0;
    flags_o[HALF_BIT] = 1'b0;
    if (mode_i == ENC_OUT) begin
      flags_o[PREDIV_BIT] = 1'b1;
      flags_o[EDGE_BIT]   = value_i[1];   // N mod 4 > 1
      flags_o[HALF_BIT]   = value_i[0];
      flags_o[PHASE_BIT]  = value_i[0];
      cnt_field = FIELD_W'(quarter);
    end else begin
      flags_o[PREDIV_BIT] = 1'b0;
      flags_o[EDGE_BIT]   = value_i[0];
      cnt_field = FIELD_W'(half);
    end
    timing_o = '0;
    timing_o[FIELD_W-1:0]         = cnt_field;
    timing_o[2*FIELD_W-1:FIELD_W] = cnt_field;
  end
endmodule

// File: rtl/hl_div_engine.sv
module hl_div_engine #(
  parameter int unsigned RATIO_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               extra_low_i,
  output logic               tick_o,
  output logic               wave_o
);
  logic [RATIO_W-1:0] cnt_q, ratio_q, act_ratio, thr;
  logic               fresh_q, extra_low_q, act_extra_low, boundary, wave_q;

  // first cycle after reset runs on the live words
  assign act_ratio     = fresh_q ? ratio_i : ratio_q;
  assign act_extra_low = fresh_q ? extra_low_i : extra_low_q;
  assign boundary      = (cnt_q == act_ratio - 1'b1);
  assign thr = act_extra_low ? ((act_ratio + 1'b1) >> 1) : (act_ratio >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      ratio_q     <= {{(RATIO_W-1){1'b0}}, 1'b1};
      extra_low_q <= 1'b0;
      fresh_q     <= 1'b1;
      wave_q      <= 1'b0;
    end else begin
      fresh_q <= 1'b0;
      if (fresh_q || boundary) begin
        ratio_q     <= ratio_i;
        extra_low_q <= extra_low_i;
      end
      cnt_q  <= boundary ? '0 : cnt_q + 1'b1;
      wave_q <= (cnt_q >= thr);
    end
  end

  assign tick_o = boundary;
  assign wave_o = wave_q;

  assert_cnt_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_ratio);
  assert_tick_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ratio_i > 1) |=> !tick_o);
  assert_hold_until_boundary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fresh_q && !tick_o) |=> $stable(ratio_q) && $stable(extra_low_q));
  assert_fresh_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh_q |-> (cnt_q == '0) && !wave_q);
endmodule

// File: rtl/hl_time_divider.sv
module hl_time_divider #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned DIV_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] timing_i,
  output logic              tick_o,
  output logic              wave_o,
  input  logic [DIV_W-1:0]  enc_value_i,
  input  logic              enc_fb_mode_i,
  input  logic [WORD_W-1:0] enc_prev_flags_i,
  output logic [WORD_W-1:0] enc_flags_o,
  output logic [WORD_W-1:0] enc_timing_o
);
  localparam int unsigned RATIO_W = FIELD_W + 2;

  logic [RATIO_W-1:0] ratio;
  logic               extra_low;

  hl_div_decode #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .RATIO_W(RATIO_W)) u_decode (
    .flags_i     (flags_i),
    .timing_i    (timing_i),
    .ratio_o     (ratio),
    .extra_low_o (extra_low)
  );

  hl_div_engine #(.RATIO_W(RATIO_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ratio_i     (ratio),
    .extra_low_i (extra_low),
    .tick_o      (tick_o),
    .wave_o      (wave_o)
  );

  hl_div_encode #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .DIV_W(DIV_W)) u_encode (
    .value_i      (enc_value_i),
    .mode_i       (hl_div_pkg::enc_mode_e'(enc_fb_mode_i)),
    .prev_flags_i (enc_prev_flags_i),
    .flags_o      (enc_flags_o),
    .timing_o     (enc_timing_o)
  );
endmodule

// File: tb/hl_time_divider_test.sv
module hl_time_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] flags_w = 32'h0;
  logic [31:0] timing_w = 32'h0203;
  logic        tick, wave;
  logic [8:0]  enc_value = 9'd0;
  logic        enc_mode = 1'b0;
  logic [31:0] enc_prev = 32'h0000_A1C3;
  logic [31:0] enc_flags, enc_timing;

  int tests = 0;
  int fails = 0;
  int prev_hi = 0;
  int prev_exp_hi = 0;
  bit have_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hl_time_divider uut (
    .clk_i(clk), .rst_ni(rst_n), .flags_i(flags_w), .timing_i(timing_w),
    .tick_o(tick), .wave_o(wave), .enc_value_i(enc_value), .enc_fb_mode_i(enc_mode),
    .enc_prev_flags_i(enc_prev), .enc_flags_o(enc_flags), .enc_timing_o(enc_timing)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", what, act, act, exp, exp);
    end
  endtask

  function automatic int exp_ratio(input logic [31:0] fl, input logic [31:0] tm);
    int base = int'(tm[7:0]) + int'(tm[15:8]) + int'(fl[8]);
    if (base == 0) base = 1;
    return fl[11] ? 2 * base + int'(fl[13]) : base;
  endfunction

  function automatic int exp_high(input int r, input logic [31:0] fl);
    if (fl[11] && !fl[15] && (r % 2 == 1)) return r / 2;
    return r - r / 2;
  endfunction

  // Called at the negedge of a tick cycle; the next period uses the new words.
  task automatic run_one(input logic [31:0] fl, input logic [31:0] tm, input string tag);
    int n = 0;
    int hi = 0;
    int er = exp_ratio(fl, tm);
    flags_w = fl;
    timing_w = tm;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        if (have_prev)
          check(prev_hi + int'(wave) == prev_exp_hi, "R3 wave high count",
                prev_hi + int'(wave), prev_exp_hi);
      end else hi += int'(wave);
    end while (!tick);
    check(n == er, {tag, " R2 R4 tick spacing"}, n, er);
    prev_hi = hi;
    prev_exp_hi = exp_high(er, fl);
    have_prev = 1;
  endtask

  task automatic enc_check(input bit mode, input int val, input logic [31:0] ef,
                           input logic [31:0] et, input string tag);
    enc_mode = mode;
    enc_value = 9'(val);
    #1;
    check(enc_flags == ef, {tag, " encoder flags"}, enc_flags, ef);
    check(enc_timing == et, {tag, " encoder timing"}, enc_timing, et);
  endtask

  task automatic sweep(input bit mode, input int lo, input int hi_n);
    enc_mode = mode;
    for (int v = lo; v <= hi_n; v++) begin
      enc_value = 9'(v);
      #1;
      check(exp_ratio(enc_flags, enc_timing) == v, "R9 encoded ratio",
            exp_ratio(enc_flags, enc_timing), v);
      run_one(enc_flags, enc_timing, "R9");
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    // R7 R8: encoder, previous flags 0xA1C3 carry stale edge/half/phase bits
    enc_check(1'b0, 8, 32'h0000_08C3, 32'h0000_0202, "R7 N=8");
    enc_check(1'b0, 7, 32'h0000_A9C3, 32'h0000_0101, "R7 N=7");
    enc_check(1'b1, 8, 32'h0000_80C3, 32'h0000_0404, "R8 N=8");
    enc_check(1'b1, 9, 32'h0000_81C3, 32'h0000_0404, "R8 N=9");

    // R6: reset state with R=5
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R6 tick in reset", tick, 0);
    check(wave == 1'b0, "R6 wave in reset", wave, 0);
    rst_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 100);
    check(n == 4, "R6 first tick edges", n, 4);

    // R1 R2 R3 R4: direct words
    run_one(32'h0000_0000, 32'h0000_0000, "R1 zero base");
    run_one(32'h0000_0000, 32'h0000_0000, "R4 ratio one");
    run_one(32'h0000_0800, 32'h0000_0000, "R1 prediv zero base");
    run_one(32'h0000_2800, 32'h0000_0000, "R2 prediv half");
    run_one(32'h0000_A800, 32'h0000_0000, "R3 phase set");
    run_one(32'h0000_2900, 32'h0000_0203, "R2 edge prediv half");
    run_one(32'h0000_A900, 32'h0000_0203, "R3 phase set odd");
    run_one(32'h0000_0100, 32'h0000_0203, "R1 edge only");
    run_one(32'h0000_0000, 32'h0000_0304, "R1 plain odd");
    run_one(32'h0000_0000, 32'h0000_0A0A, "R2 plain 20");

    // R5: change words mid-period
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    n = 4;
    flags_w = 32'h0;
    timing_w = 32'h0000_0403;
    do begin @(negedge clk); n++; end while (!tick && n < 100);
    check(n == 20, "R5 running period kept", n, 20);
    have_prev = 0;
    run_one(32'h0000_0000, 32'h0000_0403, "R5 new ratio");

    // R9: encoder-driven sweeps
    sweep(1'b0, 2, 511);
    sweep(1'b1, 2, 255);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule